// File: doc/BRIEF.md
# Serial audio clock and frame-sync generator

This block produces the timing signals of a synchronous serial audio port from one system clock qualified by an enable pulse. A chain of three dividers makes the internal bit clock. The chain is an optional halving stage, then a fixed prescaler that can be bypassed, then a programmable modulus divider. The bit clock is split into words by a word-length divider and into frames by a frame-rate divider. A one-bit-wide frame sync marks the first bit of every frame.

A register-style configuration port loads all settings in a single write strobe. The direction bit chooses the bit-clock source. With the internal source, the divided clock drives the bit-clock pin and the output enable is raised. With the external source, the pin is left undriven. The word and frame counters then follow rising edges of an external bit clock, and those edges are first passed through a synchronizer. A separate enable lets the divided clock appear on the oversampling master-clock output. Every stage runs on the system clock and uses clock enables only.

Top module: `aud_sclk_gen`

## Requirements
- R1: The internal bit-clock period is h*p*(N+1) enabled system cycles. Here h is 2 when `cfg_half`=1 and 1 otherwise, p is PRE_RATIO (default 8) when `cfg_pre`=1 and 1 otherwise, and N is `cfg_pm`.
- R2: The word clock period is W bit-clock periods. The `cfg_wl` codes 0 to 7 give W of 8, 10, 12, 16, 18, 20, 22 and 24, in that order. The word clock is high for the first W/2 bits.
- R3: A frame holds M+1 words, where M is `cfg_fr`. The frame sync repeats once per frame.
- R4: When `cfg_dir`=1, `bclk_oe`=1 and `bclk_out` carries the internal bit clock. When `cfg_dir`=0, `bclk_oe`=0 and `bclk_out`=0.
- R5: When `cfg_mce`=1, `mclk_out` carries the divided clock. When `cfg_mce`=0, `mclk_out` stays 0.
- R6: A divider with an even ratio R has an output that is high for R/2 of its input periods. A divider with an odd ratio R>1 has an output that is high for one input period. A divider with ratio 1 passes its input through.
- R7: The frame sync is high for exactly one bit-clock period. It rises on the same system edge as the word clock that starts the frame.
- R8: A configuration write clears every divider counter, the word clock and the frame sync. The first frame sync rises W*(M+1) bit periods after the write.
- R9: When `cfg_dir`=0, each rising edge of `ext_bclk` advances the word and frame counters once. The edge passes through a two-flop synchronizer, so its effect is visible within three system cycles.
- R10: While `clk_en` is low, the internal dividers hold their state. With `clk_en` high on every second cycle, all internal periods double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Enable pulse qualifying the system clock |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_half | input | 1 | Halving stage select |
| cfg_pre | input | 1 | Fixed prescaler select |
| cfg_pm | input | PM_W | Modulus value N (ratio N+1) |
| cfg_wl | input | 3 | Word-length code |
| cfg_fr | input | FR_W | Frame-rate value M (ratio M+1) |
| cfg_dir | input | 1 | 1 = internal bit clock driven, 0 = external |
| cfg_mce | input | 1 | Master-clock output enable |
| ext_bclk | input | 1 | External bit clock |
| bclk_out | output | 1 | Bit-clock output value |
| bclk_oe | output | 1 | Bit-clock output enable |
| mclk_out | output | 1 | Oversampling master clock |
| wclk_out | output | 1 | Word clock |
| fsync_out | output | 1 | Frame sync |

## Verification
The hardest case to reach from the ports is external-clock mode. There, the frame sync depends on an asynchronous input that passes through the synchronizer, and the counters start from the cleared state left by a configuration write. The bench writes the configuration while its own external clock is held low. It then produces external edges at a chosen spacing and counts them. It checks that no frame sync appears before the last edge of the frame, and that one does appear within the synchronizer latency after that edge. A restart test counts exact cycles from the write strobe to the first frame sync.

// File: rtl/aud_sclk_pkg.sv
package aud_sclk_pkg;

   localparam int WL_CODE_W = 3;
   localparam int WORD_CW   = 5;

   typedef enum logic {BSRC_EXT = 1'b0, BSRC_INT = 1'b1} bsrc_e;

   // word-length code to (ratio - 1): 8,10,12,16,18,20,22,24
   function automatic logic [WORD_CW-1:0] wl_ratio_m1(input logic [WL_CODE_W-1:0] code);
      logic [WORD_CW-1:0] c5;
      c5 = WORD_CW'(code);
      if (code < WL_CODE_W'(3))
         return WORD_CW'(7) + (c5 << 1);
      else
         return WORD_CW'(9) + (c5 << 1);
   endfunction

endpackage

// File: rtl/aud_clk_div.sv
module aud_clk_div #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_en,
   input  logic          lvl_i,
   input  logic [CW-1:0] ratio_m1,
   output logic          tick_o,
   output logic          lvl_o
);
   localparam int RW = CW + 1;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("aud_clk_div: CW must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic          lvl_q;
   logic [RW-1:0] ratio_w;
   logic [RW-1:0] half_w;

   always_comb begin
      ratio_w = {1'b0, ratio_m1} + RW'(1);
      // even ratio: half period high; odd ratio: one input period high
      half_w  = ratio_m1[0] ? (ratio_w >> 1) : RW'(1);
      tick_o  = in_en & (cnt_q == ratio_m1);
      cnt_nx  = tick_o ? '0 : cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (in_en) begin
         cnt_q <= cnt_nx;
         if (tick_o)
            lvl_q <= 1'b1;
         else if ({1'b0, cnt_nx} == half_w)
            lvl_q <= 1'b0;
      end
   end

   // unity ratio passes the input clock through
   assign lvl_o = (ratio_m1 == '0) ? lvl_i : lvl_q;

   // R6: counter never leaves its ratio window
   a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ratio_m1);

   // R10: level only moves on an enabled input cycle or a clear
   a_r10_lvl_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl_q) |-> $past(in_en || clr));

endmodule

// File: rtl/aud_edge_sync.sv
module aud_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("aud_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], d_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

   // R9: a detected edge lasts exactly one system cycle
   a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
   import aud_sclk_pkg::*;
#(
   parameter int FR_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 bit_en,
   input  logic [WL_CODE_W-1:0] wl_code,
   input  logic [FR_W-1:0]      fr_m1,
   output logic                 wclk_o,
   output logic                 fsync_o
);
   logic               word_tick;
   logic               frame_tick;
   logic               frm_lvl;
   logic               fsync_q;
   logic [WORD_CW-1:0] word_m1;

   assign word_m1 = wl_ratio_m1(wl_code);

   aud_clk_div #(.CW(WORD_CW)) u_word_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_en    (bit_en),
      .lvl_i    (1'b0),
      .ratio_m1 (word_m1),
      .tick_o   (word_tick),
      .lvl_o    (wclk_o)
   );

   aud_clk_div #(.CW(FR_W)) u_frame_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_en    (word_tick),
      .lvl_i    (wclk_o),
      .ratio_m1 (fr_m1),
      .tick_o   (frame_tick),
      .lvl_o    (frm_lvl)
   );

   // set at the frame boundary, dropped at the following bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fsync_q <= 1'b0;
      else if (clr)
         fsync_q <= 1'b0;
      else if (bit_en)
         fsync_q <= frame_tick;
   end

   assign fsync_o = fsync_q;

   // R7: frame sync starts together with a word
   a_r7_fsync_with_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync_q) |-> $rose(wclk_o));

   // R3: frame clock only rises at a frame boundary
   a_r3_frame_rise_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_lvl) |-> fsync_q);

   // R8: configuration write leaves word clock and frame sync low
   a_r8_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!fsync_q && !wclk_o));

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
   import aud_sclk_pkg::*;
#(
   parameter int PM_W        = 8,
   parameter int FR_W        = 5,
   parameter int PRE_RATIO   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clk_en,
   input  logic                 cfg_wr,
   input  logic                 cfg_half,
   input  logic                 cfg_pre,
   input  logic [PM_W-1:0]      cfg_pm,
   input  logic [WL_CODE_W-1:0] cfg_wl,
   input  logic [FR_W-1:0]      cfg_fr,
   input  logic                 cfg_dir,
   input  logic                 cfg_mce,
   input  logic                 ext_bclk,
   output logic                 bclk_out,
   output logic                 bclk_oe,
   output logic                 mclk_out,
   output logic                 wclk_out,
   output logic                 fsync_out
);
   localparam int PRE_CW = (PRE_RATIO > 2) ? $clog2(PRE_RATIO) : 1;

   generate
      if (PRE_RATIO < 2) begin : g_bad_pre
         $error("aud_sclk_gen: PRE_RATIO must be at least 2");
      end
      if (PM_W < 1 || PM_W > 16) begin : g_bad_pm
         $error("aud_sclk_gen: PM_W out of range");
      end
      if (FR_W < 1 || FR_W > 8) begin : g_bad_fr
         $error("aud_sclk_gen: FR_W out of range");
      end
   endgenerate

   // configuration register
   logic                 half_q;
   logic                 pre_q;
   logic [PM_W-1:0]      pm_q;
   logic [WL_CODE_W-1:0] wl_q;
   logic [FR_W-1:0]      fr_q;
   bsrc_e                src_q;
   logic                 mce_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         pre_q  <= 1'b0;
         pm_q   <= '0;
         wl_q   <= '0;
         fr_q   <= '0;
         src_q  <= BSRC_EXT;
         mce_q  <= 1'b0;
      end else if (cfg_wr) begin
         half_q <= cfg_half;
         pre_q  <= cfg_pre;
         pm_q   <= cfg_pm;
         wl_q   <= cfg_wl;
         fr_q   <= cfg_fr;
         src_q  <= cfg_dir ? BSRC_INT : BSRC_EXT;
         mce_q  <= cfg_mce;
      end
   end

   // bit-clock cascade
   logic              half_tick, half_lvl;
   logic              pre_tick,  pre_lvl;
   logic              int_tick,  int_lvl;
   logic [0:0]        half_m1;
   logic [PRE_CW-1:0] pre_m1;

   assign half_m1 = half_q ? 1'b1 : 1'b0;
   assign pre_m1  = pre_q ? PRE_CW'(PRE_RATIO - 1) : '0;

   aud_clk_div #(.CW(1)) u_half_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cfg_wr),
      .in_en    (clk_en),
      .lvl_i    (clk_en),
      .ratio_m1 (half_m1),
      .tick_o   (half_tick),
      .lvl_o    (half_lvl)
   );

   aud_clk_div #(.CW(PRE_CW)) u_pre_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cfg_wr),
      .in_en    (half_tick),
      .lvl_i    (half_lvl),
      .ratio_m1 (pre_m1),
      .tick_o   (pre_tick),
      .lvl_o    (pre_lvl)
   );

   aud_clk_div #(.CW(PM_W)) u_mod_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cfg_wr),
      .in_en    (pre_tick),
      .lvl_i    (pre_lvl),
      .ratio_m1 (pm_q),
      .tick_o   (int_tick),
      .lvl_o    (int_lvl)
   );

   // external bit-clock edge detection
   logic ext_rise;

   aud_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (ext_bclk),
      .rise_o (ext_rise)
   );

   logic bit_en;
   assign bit_en = (src_q == BSRC_INT) ? int_tick : ext_rise;

   aud_frame_seq #(.FR_W(FR_W)) u_frame_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cfg_wr),
      .bit_en  (bit_en),
      .wl_code (wl_q),
      .fr_m1   (fr_q),
      .wclk_o  (wclk_out),
      .fsync_o (fsync_out)
   );

   assign bclk_oe  = (src_q == BSRC_INT);
   assign bclk_out = (src_q == BSRC_INT) & int_lvl;
   assign mclk_out = mce_q & int_lvl;

   // R4: external source never drives the pin
   a_r4_ext_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == BSRC_EXT) |-> (!bclk_oe && !bclk_out));

   // R5: master clock silent while disabled
   a_r5_mclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !mce_q |-> !mclk_out);

endmodule

// File: tb/aud_sclk_gen_tb_top.sv
module aud_sclk_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1;
   logic       cfg_wr = 1'b0;
   logic       cfg_half = 1'b0;
   logic       cfg_pre = 1'b0;
   logic [7:0] cfg_pm = '0;
   logic [2:0] cfg_wl = '0;
   logic [4:0] cfg_fr = '0;
   logic       cfg_dir = 1'b0;
   logic       cfg_mce = 1'b0;
   logic       ext_bclk = 1'b0;
   logic       bclk_out, bclk_oe, mclk_out, wclk_out, fsync_out;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;
   int en_mode = 0;
   logic en_tog = 1'b0;

   int fs_rises = 0;
   int bclk_moves = 0;
   int mclk_rises = 0;
   logic fs_prev = 1'b0, bc_prev = 1'b0, mc_prev = 1'b0;

   always #4 clk = ~clk;

   aud_sclk_gen dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_wr(cfg_wr),
      .cfg_half(cfg_half), .cfg_pre(cfg_pre), .cfg_pm(cfg_pm),
      .cfg_wl(cfg_wl), .cfg_fr(cfg_fr), .cfg_dir(cfg_dir), .cfg_mce(cfg_mce),
      .ext_bclk(ext_bclk), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
      .mclk_out(mclk_out), .wclk_out(wclk_out), .fsync_out(fsync_out)
   );

   always @(negedge clk) begin
      en_tog <= ~en_tog;
      case (en_mode)
         0: clk_en <= 1'b1;
         1: clk_en <= en_tog;
         default: clk_en <= 1'b0;
      endcase
      if (fsync_out && !fs_prev) fs_rises <= fs_rises + 1;
      if (bclk_out != bc_prev) bclk_moves <= bclk_moves + 1;
      if (mclk_out && !mc_prev) mclk_rises <= mclk_rises + 1;
      fs_prev <= fsync_out;
      bc_prev <= bclk_out;
      mc_prev <= mclk_out;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic sig(input int sel);
      case (sel)
         0: return bclk_out;
         1: return mclk_out;
         2: return wclk_out;
         default: return fsync_out;
      endcase
   endfunction

   task automatic wr_cfg(input bit h, input bit p, input int pm, input int wl,
                         input int fr, input bit dir, input bit mce);
      @(negedge clk);
      cfg_half = h; cfg_pre = p; cfg_pm = 8'(pm); cfg_wl = 3'(wl);
      cfg_fr = 5'(fr); cfg_dir = dir; cfg_mce = mce; cfg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // period and high time of a signal, in system cycles, sampled at negedges
   task automatic measure(input int sel, output int per, output int hi);
      logic prv;
      int n;
      per = -1; hi = -1;
      prv = sig(sel);
      n = 0;
      while (!(sig(sel) && !prv) && n < 3000) begin
         prv = sig(sel); @(negedge clk); n++;
      end
      if (n >= 3000) return;
      n = 0;
      while (sig(sel) && n < 3000) begin @(negedge clk); n++; end
      hi = n;
      while (!sig(sel) && n < 3000) begin @(negedge clk); n++; end
      if (n < 3000) per = n;
   endtask

   task automatic t_reset;
      chk(bclk_oe == 1'b0, "R4 reset oe", bclk_oe, 0);
      chk(bclk_out == 1'b0, "R4 reset bclk", bclk_out, 0);
      chk(mclk_out == 1'b0, "R5 reset mclk", mclk_out, 0);
      chk(wclk_out == 1'b0, "R2 reset wclk", wclk_out, 0);
      chk(fsync_out == 1'b0, "R7 reset fsync", fsync_out, 0);
   endtask

   task automatic t_bit_cascade;
      int per, hi;
      wr_cfg(1, 0, 2, 0, 0, 1, 0);
      chk(bclk_oe == 1'b1, "R4 internal oe", bclk_oe, 1);
      measure(0, per, hi);
      chk(per == 6, "R1 half+mod3 period", per, 6);
      chk(hi == 2, "R6 odd mod high", hi, 2);
      wr_cfg(0, 1, 0, 0, 0, 1, 0);
      measure(0, per, hi);
      chk(per == 8, "R1 prescale period", per, 8);
      chk(hi == 4, "R6 even prescale duty", hi, 4);
      wr_cfg(1, 1, 1, 0, 0, 1, 0);
      measure(0, per, hi);
      chk(per == 32, "R1 full cascade period", per, 32);
      chk(hi == 16, "R6 full cascade duty", hi, 16);
      wr_cfg(0, 0, 4, 0, 0, 1, 0);
      measure(0, per, hi);
      chk(per == 5, "R1 mod5 period", per, 5);
      chk(hi == 1, "R6 odd ratio one cycle", hi, 1);
      wr_cfg(0, 0, 255, 0, 0, 1, 0);
      measure(0, per, hi);
      chk(per == 256, "R1 max modulus period", per, 256);
   endtask

   task automatic t_word_map;
      int per, hi;
      int exp_w;
      for (int c = 0; c < 8; c++) begin
         exp_w = (c < 3) ? 8 + 2 * c : 10 + 2 * c;
         wr_cfg(1, 0, 0, c, 0, 1, 0);
         measure(2, per, hi);
         chk(per == 2 * exp_w, "R2 word period", per, 2 * exp_w);
         chk(hi == exp_w, "R2 word high half", hi, exp_w);
      end
   endtask

   task automatic t_frame;
      int per, hi;
      wr_cfg(1, 0, 0, 3, 2, 1, 0);
      measure(3, per, hi);
      chk(per == 96, "R3 three-word frame", per, 96);
      chk(hi == 2, "R7 fsync one bit wide", hi, 2);
      wr_cfg(1, 0, 0, 0, 0, 1, 0);
      measure(3, per, hi);
      chk(per == 16, "R3 one-word frame", per, 16);
      wr_cfg(0, 0, 0, 0, 31, 1, 0);
      measure(3, per, hi);
      chk(per == 256, "R3 max frame ratio", per, 256);
   endtask

   task automatic t_align;
      logic wprev, fprev;
      int n;
      wr_cfg(1, 0, 1, 1, 1, 1, 0);
      wprev = wclk_out; fprev = fsync_out; n = 0;
      while (!(fsync_out && !fprev) && n < 2000) begin
         wprev = wclk_out; fprev = fsync_out; @(negedge clk); n++;
      end
      chk(wclk_out == 1'b1 && wprev == 1'b0, "R7 fsync with word rise",
          int'(wclk_out), 1);
      chk(bclk_out == 1'b1, "R7 fsync on bit start", bclk_out, 1);
   endtask

   task automatic t_restart;
      int n;
      wr_cfg(1, 0, 0, 0, 1, 1, 0);
      chk(wclk_out == 1'b0 && fsync_out == 1'b0, "R8 cleared after write",
          int'(wclk_out) + int'(fsync_out), 0);
      n = 0;
      while (!fsync_out && n < 2000) begin @(negedge clk); n++; end
      chk(n == 32, "R8 first fsync delay", n, 32);
   endtask

   task automatic ext_pulse(input int hi, input int lo);
      ext_bclk = 1'b1;
      repeat (hi) @(negedge clk);
      ext_bclk = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic t_ext;
      int base;
      ext_bclk = 1'b0;
      wr_cfg(0, 0, 3, 0, 0, 0, 1);
      repeat (4) @(negedge clk);
      base = fs_rises;
      for (int i = 0; i < 7; i++) ext_pulse(3, 3);
      chk(fs_rises == base, "R9 no fsync before 8th edge", fs_rises - base, 0);
      chk(bclk_oe == 1'b0 && bclk_out == 1'b0, "R4 external undriven",
          int'(bclk_oe) + int'(bclk_out), 0);
      ext_bclk = 1'b1;
      repeat (4) @(negedge clk);
      chk(fsync_out == 1'b1, "R9 fsync after 8th edge", fsync_out, 1);
      chk(wclk_out == 1'b1, "R9 word rise after 8th edge", wclk_out, 1);
      ext_bclk = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 8; i++) ext_pulse(3, 3);
      chk(fs_rises == base + 2, "R9 one fsync per frame", fs_rises - base, 2);
      chk(mclk_rises > 0, "R5 mclk runs in external mode", mclk_rises, 1);
   endtask

   task automatic t_mclk;
      int per, hi, base;
      wr_cfg(0, 0, 4, 0, 0, 1, 1);
      measure(1, per, hi);
      chk(per == 5, "R5 mclk period", per, 5);
      chk(hi == 1, "R5 mclk high", hi, 1);
      wr_cfg(0, 0, 4, 0, 0, 1, 0);
      base = mclk_rises;
      repeat (40) @(negedge clk);
      chk(mclk_rises == base && mclk_out == 1'b0, "R5 mclk off",
          mclk_rises - base, 0);
   endtask

   task automatic t_clk_en;
      int per, hi, base;
      wr_cfg(0, 0, 3, 0, 0, 1, 0);
      repeat (10) @(negedge clk);
      en_mode = 2;
      @(negedge clk);
      base = bclk_moves;
      repeat (20) @(negedge clk);
      chk(bclk_moves == base, "R10 held without enable", bclk_moves - base, 0);
      en_mode = 1;
      wr_cfg(0, 0, 1, 0, 0, 1, 0);
      measure(0, per, hi);
      chk(per == 4, "R10 half-rate enable period", per, 4);
      chk(hi == 2, "R10 half-rate enable high", hi, 2);
      en_mode = 0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset;
      t_bit_cascade;
      t_word_map;
      t_frame;
      t_align;
      t_restart;
      t_ext;
      t_mclk;
      t_clk_en;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule